// File: doc/BRIEF.md
# Receive-Lane Clock-Crossing FIFO

This block carries deserialized words from one receive lane into the fabric clock domain. Words arrive on a divided sample clock, one per clock cycle. They are read on a second clock that runs at the same frequency with an unknown phase. The storage is an eight-position ring. The write pointer moves on every write-clock cycle and never stops. The read pointer moves only when the consumer asks for a word and the ring is not empty. The write clock is also driven back out, so that this lane or its neighbours can use it as their read clock.

An empty flag tells the reader when it has caught up with the writer. The flag is built from the write pointer, which crosses into the read domain in Gray code through two flops. A consumer normally drives read enable from the inverted empty flag through one register. With that arrangement, words arrive in order at a steady rate of one per cycle. If read enable stays low, the frozen read position keeps being overwritten. The output then shows a fresh word once every eight read cycles.

A width parameter selects 4-bit or 8-bit lanes. In the 4-bit case, the output also carries a replica of the serial line next to the nibble. A same-clock parameter removes the synchronizer for designs that read on the write clock itself.

Top module: `rx_lane_cdc_fifo`

## Requirements
- R1: While rst_n is low, empty is 1 and q is 0. Both pointers and all entries are cleared.
- R2: On every wr_clk edge out of reset, the input word is stored at the write position and that position advances by one, wrapping from 7 to 0. Words read with read enable following the inverted empty flag come out in write order, each one greater than the last (modulo the word width), at any phase between the clocks.
- R3: The read position advances on an rd_clk edge only when rd_en is 1 and empty is 0; otherwise it holds. In steady state with rd_en following the inverted empty flag, a read happens on nearly every cycle.
- R4: empty is 1 when the synchronized write position equals the read position. After the first write following reset, empty is still 1 after the first rd_clk edge and 0 after the second.
- R5: When rd_en is taken from the inverted empty flag through one register, the first word written after reset appears on q on the third rd_clk edge after its write edge.
- R6: With rd_en held low, q reloads from the frozen position on every rd_clk edge. It therefore changes exactly every 8 read cycles, and each new word is 8 steps further in the write sequence. empty is 1 for exactly one read cycle in every eight.
- R7: With DATA_W = 4, q[3:0] carries wr_word[3:0] and q[5] carries wr_word[4], the serial replica stored with the same word. q[7:6] and q[4] are 0, and wr_word[7:5] has no effect on q.
- R8: With DATA_W = 8, all eight bits of q carry the stored word.
- R9: With SYNC_MODE = 1, no synchronizer is used. empty goes to 0 in the same cycle as the first write, and that word reaches q one edge after its write edge when rd_en follows the inverted empty flag.
- R10: wr_clk_out is a copy of wr_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Divided sample clock; one word is written per edge |
| wr_word | input | 8 | Deserialized word; in 4-bit mode bits [3:0] are data and bit 4 is the serial sample |
| rd_clk | input | 1 | Read clock, same frequency as wr_clk, any phase |
| rd_en | input | 1 | Read request |
| q | output | 8 | Registered read data |
| empty | output | 1 | Ring empty, in the read domain |
| wr_clk_out | output | 1 | Copy of the write clock |

## Verification
On every cycle, the assertions check the following. The write position steps by exactly one Gray code each cycle. The read position changes by at most one Gray bit. The read position stays put whenever read enable is low or the ring looks empty. Some behaviour only the bench scenarios can show: the two-edge delay of the empty flag, the three-edge first-word latency, the in-order word stream, the eight-cycle refresh while reads are withheld, the serial replica in 4-bit mode, and the same-clock variant. The bench repeats each of these at several phase offsets between the two clocks.

// File: rtl/rx_lane_cdc_fifo.sv
module rx_lane_cdc_fifo #(
  parameter int DATA_W    = 8,
  parameter int SYNC_MODE = 0,
  parameter int DEPTH     = 8
) (
  input  logic       rst_n,
  input  logic       wr_clk,
  input  logic [7:0] wr_word,
  input  logic       rd_clk,
  input  logic       rd_en,
  output logic [7:0] q,
  output logic       empty,
  output logic       wr_clk_out
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = (DATA_W == 4) ? 5 : 8;

  function automatic logic [AW-1:0] to_gray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] entry_in, q_reg;
  logic [AW-1:0] wr_bin, wr_gray, rd_bin, rd_gray, wr_gray_seen;
  logic          rd_go;

  generate
    if (DATA_W == 4) begin : g_nib
      assign entry_in = wr_word[4:0];
      assign q = {2'b00, q_reg[4], 1'b0, q_reg[3:0]};
    end else begin : g_byte
      assign entry_in = wr_word;
      assign q = q_reg;
    end
  endgenerate

  assign wr_clk_out = wr_clk;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      mem[wr_bin] <= entry_in;
      wr_bin      <= wr_bin + 1'b1;
      wr_gray     <= to_gray(wr_bin + 1'b1);
    end
  end

  // R2
  wr_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(wr_gray ^ $past(wr_gray)) == 1);

  generate
    if (SYNC_MODE != 0) begin : g_same
      assign wr_gray_seen = wr_gray;
    end else begin : g_cdc
      logic [AW-1:0] sync1, sync2;
      always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
          sync1 <= '0;
          sync2 <= '0;
        end else begin
          sync1 <= wr_gray;
          sync2 <= sync1;
        end
      end
      assign wr_gray_seen = sync2;
    end
  endgenerate

  assign empty = (wr_gray_seen == rd_gray);
  assign rd_go = rd_en & ~empty;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      q_reg   <= '0;
    end else begin
      q_reg <= mem[rd_bin];
      if (rd_go) begin
        rd_bin  <= rd_bin + 1'b1;
        rd_gray <= to_gray(rd_bin + 1'b1);
      end
    end
  end

  // R3
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_gray));

  // R3
  rd_empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |=> $stable(rd_gray));

  // R3
  rd_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: tb/rx_lane_cdc_fifo_test.sv
`timescale 1ns/1ps
module rx_lane_cdc_fifo_test;
  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  real  rd_shift = 0.25;
  logic [7:0] cnt = 8'h00;
  logic [7:0] w8, w4, q8, q4, qs;
  logic e8, e4, es, en0 = 0, en1 = 0, en2 = 0, wco, wco4, wcos;
  int checks = 0, fails = 0;
  bit done = 0, active = 0, follow = 0;
  int unsigned rd_edges = 0, wr_edges = 0, base_rd = 0, base_wr = 0;

  int cyc[3], last_chg[3], nchg[3], nreads[3], nempty[3], first_edge[3];
  logic [7:0] last_q[3], last_v[3];
  bit pend[3], got[3];

  always #2 wr_clk = ~wr_clk;
  initial forever begin
    if (rd_shift != 0.0) begin #(rd_shift); rd_shift = 0.0; end
    #2 rd_clk = ~rd_clk;
  end

  assign w8 = cnt;
  assign w4 = {cnt[7:5], ~^cnt[3:0], cnt[3:0]};

  rx_lane_cdc_fifo #(.DATA_W(8), .SYNC_MODE(0)) uut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_word(w8), .rd_clk(rd_clk), .rd_en(en0),
    .q(q8), .empty(e8), .wr_clk_out(wco));
  rx_lane_cdc_fifo #(.DATA_W(4), .SYNC_MODE(0)) uut4 (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_word(w4), .rd_clk(rd_clk), .rd_en(en1),
    .q(q4), .empty(e4), .wr_clk_out(wco4));
  rx_lane_cdc_fifo #(.DATA_W(8), .SYNC_MODE(1)) uut_sync (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_word(w8), .rd_clk(wr_clk), .rd_en(en2),
    .q(qs), .empty(es), .wr_clk_out(wcos));

  always @(posedge rd_clk) rd_edges++;
  always @(posedge wr_clk) wr_edges++;
  always @(negedge wr_clk) cnt <= rst_n ? cnt + 8'd1 : 8'd0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic observe(input int k, input logic [7:0] qv, input logic emp,
                         input int unsigned edges);
    logic [7:0] v, expq, d;
    if (!active) return;
    cyc[k]++;
    if (pend[k]) begin
      v = got[k] ? last_v[k] + 8'd1 : 8'd0;
      if (k == 1) v = v & 8'h0F;
      expq = (k == 1) ? {2'b00, ~^v[3:0], 1'b0, v[3:0]} : v;
      if (!got[k]) first_edge[k] = int'(edges);
      check(qv == expq, (k == 1) ? "R7" : ((k == 2) ? "R9" : "R2"),
            "word order", qv, expq);
      last_v[k] = v; got[k] = 1; nreads[k]++;
    end
    if (!follow) begin
      if (qv !== last_q[k]) begin
        if (nchg[k] > 0) begin
          d = qv - last_q[k];
          if (k == 1) d = d & 8'h0F;
          check(cyc[k] - last_chg[k] == 8, "R6", "refresh interval",
                cyc[k] - last_chg[k], 8);
          check(d == 8'd8, "R6", "refresh step", d, 8);
        end
        last_chg[k] = cyc[k]; nchg[k]++;
      end
      if (emp && cyc[k] > 16 && cyc[k] <= 48) nempty[k]++;
    end
    last_q[k] = qv;
    pend[k] = follow && !emp;
  endtask

  always @(negedge rd_clk) begin
    observe(0, q8, e8, rd_edges);
    observe(1, q4, e4, rd_edges);
    en0 = follow && !e8;
    en1 = follow && !e4;
  end

  always @(negedge wr_clk) begin
    observe(2, qs, es, wr_edges);
    en2 = follow && !es;
  end

  task automatic clear_state();
    for (int k = 0; k < 3; k++) begin
      cyc[k] = 0; last_chg[k] = 0; nchg[k] = 0; nreads[k] = 0; nempty[k] = 0;
      first_edge[k] = -1; last_q[k] = 0; last_v[k] = 0; pend[k] = 0; got[k] = 0;
    end
  endtask

  task automatic enter_reset(input real shift);
    rst_n = 0; active = 0;
    rd_shift = shift;
    repeat (6) @(posedge wr_clk);
    clear_state();
    @(negedge rd_clk);
    check(e8 === 1'b1, "R1", "empty in reset", e8, 1);
    check(q8 === 8'h00, "R1", "q in reset", q8, 0);
    check(e4 === 1'b1 && q4 === 8'h00, "R1", "4-bit reset", q4, 0);
    check(es === 1'b1 && qs === 8'h00, "R9", "sync reset", qs, 0);
    check(wco === wr_clk && wco4 === wr_clk, "R10", "clock copy", wco, wr_clk);
  endtask

  task automatic release_reset();
    @(negedge wr_clk);
    #0.5 rst_n = 1; active = 1;
    @(posedge wr_clk);
    #0.01;
    base_wr = wr_edges;
    base_rd = rd_edges;
    check(wcos === wr_clk, "R10", "clock copy high", wcos, wr_clk);
  endtask

  initial begin
    real shifts[5];
    shifts[0] = 0.0; shifts[1] = 0.5; shifts[2] = 1.1; shifts[3] = 0.9; shifts[4] = 0.6;
    for (int p = 0; p < 5; p++) begin
      follow = 0;
      enter_reset(shifts[p]);
      release_reset();
      check(es == 1'b0, "R9", "sync empty falls with write", es, 0);
      wait (rd_edges == base_rd + 1);
      @(negedge rd_clk);
      check(e8 == 1'b1 && e4 == 1'b1, "R4", "empty after first edge", e8, 1);
      wait (rd_edges == base_rd + 2);
      @(negedge rd_clk);
      check(e8 == 1'b0 && e4 == 1'b0, "R4", "empty after second edge", e8, 0);
      repeat (60) @(negedge rd_clk);
      for (int k = 0; k < 3; k++) begin
        check(nempty[k] == 4, "R6", "empty one in eight", nempty[k], 4);
        check(nchg[k] >= 5, "R6", "refresh count", nchg[k], 5);
      end

      follow = 1;
      enter_reset(0.0);
      release_reset();
      repeat (60) @(negedge rd_clk);
      check(first_edge[0] == int'(base_rd) + 3, "R5", "first word edge", first_edge[0], base_rd + 3);
      check(first_edge[1] == int'(base_rd) + 3, "R5", "first nibble edge", first_edge[1], base_rd + 3);
      check(first_edge[2] == int'(base_wr) + 1, "R9", "sync first word edge", first_edge[2], base_wr + 1);
      for (int k = 0; k < 3; k++)
        check(nreads[k] >= 50, "R3", "read rate", nreads[k], 50);
      check(last_v[0] > 8'h0F, "R8", "full byte range", last_v[0], 16);
      check(q4[7:6] == 2'b00 && q4[4] == 1'b0, "R7", "unused bits zero", q4, {2'b00, q4[5], 1'b0, q4[3:0]});
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule